// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Set-Associative Data Cache

This block is a set-associative data cache that can begin reading a set before the address translation is done. The requester gives the word position inside the page on the request cycle. That position is never translated, so it alone selects the set, and the tag and valid bits of every way in that set are read into registers on the same clock edge. One cycle later the translation unit supplies the physical page number, or a fault. Each way's stored physical tag is compared against that page number in the same cycle, and the block reports hit or miss together with the selected word.

On a read miss the block asks memory for the whole line, using a simple request and response pair. It writes the returned line into the way chosen by that set's round-robin pointer. A write that hits updates one word in place. A write that misses changes nothing, and a faulted access changes nothing. The requester re-issues a read that missed once the line is present.

Capacity grows by adding ways, because the index and block offset together exactly fill the page offset. With the default 4 KB pages, 32-byte lines, 128 sets and 4 ways, the cache holds 16 KB.

Top module: `vipt_cache`

## Requirements
- R1: After reset every way of every set is invalid, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0. The first read of any address therefore misses.
- R2: `req_woff` is the word address within the page. Bits [9:3] select one of 128 sets and bits [2:0] select one of 8 32-bit words in the line (word k is line bits [32k+31:32k]). The same physical page at two different set indices gives two separate lines.
- R3: A request accepted on a clock edge (`req_valid` and `req_ready` both 1) yields `rsp_valid` = 1 in the following cycle. In that cycle `xlt_ppn` and `xlt_fault` are sampled, and `rsp_hit` is 1 exactly when a valid way of the set holds a tag equal to `xlt_ppn` and `xlt_fault` is 0.
- R4: A read that misses without a fault raises `mem_req_valid` from the next cycle, with `mem_req_line` = {ppn, set index}. Both stay steady until the cycle in which `mem_rsp_valid` is 1. `req_ready` is 0 from the miss cycle until the fill has completed.
- R5: A fill writes `mem_rsp_line` into the victim way and marks it valid. A later read of that page and set hits and returns the selected word of the line. At most one way of a set matches a given page.
- R6: Each set has its own round-robin victim pointer that starts at way 0 and advances by one on every fill of that set. Four different pages fit in one set at the same time, and a fifth evicts the first one filled.
- R7: An access with `xlt_fault` = 1 reports `rsp_hit` = 0 even when the page is resident, starts no fill, and writes no data.
- R8: A write that hits replaces the selected word, and `rsp_hit` is 1. A write that misses reports `rsp_hit` = 0, starts no fill, and changes no line.
- R9: While every access hits, a new request is accepted on every clock edge, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request is accepted on this edge if valid |
| req_write | input | 1 | 1 = write one word, 0 = read |
| req_woff | input | 10 | Word address within the page: set [9:3], word [2:0] |
| req_wdata | input | 32 | Write data |
| xlt_ppn | input | 20 | Physical page number, valid the cycle after acceptance |
| xlt_fault | input | 1 | Translation fault, same cycle as `xlt_ppn` |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_rdata | output | 32 | Read word on a read hit |
| mem_req_valid | output | 1 | Line fetch request, held until answered |
| mem_req_line | output | 27 | Physical line number {ppn, set} |
| mem_rsp_valid | input | 1 | Line data present (one cycle) |
| mem_rsp_line | input | 256 | Line data |

## Verification
Two things can land in the same cycle. The lookup of one access, which decides whether a fill starts, meets the set read of the next access, which the requester is already presenting. The bench provokes this by issuing a missing read immediately followed by a read that should hit in another set. The `req_ready` drop must hold back the second request until the line is in. The scoreboard judges the result: responses must arrive in order with the right hit flag and data, and exactly one line fetch must appear, with the expected line number. A write hit followed at once by a read of the same word shows that the word update and the following lookup do not interfere.

// File: rtl/vipt_pkg.sv
// Shared types of the VIPT cache.
// Assumes: nothing beyond IEEE 1800-2017.
package vipt_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
// Per-way physical tag and valid storage. The set is read into output
// registers on the edge that accepts a request, so the read overlaps
// translation. Fills write one way of one set.
// Assumes: fill_en never coincides with rd_en (the top stalls during fills).
module vipt_tag_store #(
    parameter int IDX_W = 7,
    parameter int WAYS  = 4,
    parameter int TAG_W = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic [IDX_W-1:0]           rd_idx,
    input  logic                       fill_en,
    input  logic [IDX_W-1:0]           fill_idx,
    input  logic [WAYS-1:0]            fill_sel,
    input  logic [TAG_W-1:0]           fill_tag,
    output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
    output logic [WAYS-1:0]            rd_vld
);
    localparam int SETS = 1 << IDX_W;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tags [SETS];
        logic [SETS-1:0]  vld;
        logic [TAG_W-1:0] tag_q;
        logic             vld_q;

        // Store the tag of a filled line.
        always_ff @(posedge clk) begin
            if (fill_en && fill_sel[w]) tags[fill_idx] <= fill_tag;
        end

        // Valid bits: cleared by reset, set by a fill.
        always_ff @(posedge clk) begin
            if (!rst_n)                      vld <= '0;
            else if (fill_en && fill_sel[w]) vld[fill_idx] <= 1'b1;
        end

        // Registered set read, started with the request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q <= '0;
                vld_q <= 1'b0;
            end else if (rd_en) begin
                tag_q <= tags[rd_idx];
                vld_q <= vld[rd_idx];
            end
        end

        assign rd_tag[w] = tag_q;
        assign rd_vld[w] = vld_q;
    end
endmodule

// File: rtl/vipt_way_match.sv
// Compares the W stored physical tags with the translated page number
// and encodes the matching way.
// Assumes: at most one valid way of a set holds a given tag.
module vipt_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            vld,
    input  logic [TAG_W-1:0]           ppn,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld[w] && (tags[w] == ppn);
    end

    // Encode the matching way number.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |hit_vec;

    assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/vipt_rr_victim.sv
// Per-set round-robin victim pointer: names the way the next fill of a
// set uses, and steps on each fill of that set.
// Assumes: WAYS is a power of two, so the pointer wraps naturally.
module vipt_rr_victim #(
    parameter int IDX_W = 7,
    parameter int WAYS  = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             advance,
    output logic [WAY_W-1:0] way
);
    localparam int SETS = 1 << IDX_W;

    logic [WAY_W-1:0] ptr_q [SETS];

    // Reset all pointers to way 0; step the pointer of a filled set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (advance) begin
            ptr_q[idx] <= ptr_q[idx] + 1'b1;
        end
    end

    assign way = ptr_q[idx];

    assert_ptr_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (ptr_q[$past(idx)] != $past(way)));
endmodule

// File: rtl/vipt_data_store.sv
// Line data storage, addressed by {set, way}. Reads one word without a
// clock; writes either one word (write hit) or a whole line (fill).
// Assumes: word write and line fill never occur in the same cycle.
module vipt_data_store #(
    parameter int IDX_W   = 7,
    parameter int WAYS    = 4,
    parameter int LINE_W  = 256,
    parameter int WORD_W  = 32,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int WSEL_W = $clog2(LINE_W / WORD_W)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [WSEL_W-1:0] rd_wsel,
    output logic [WORD_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [LINE_W-1:0] fill_line
);
    localparam int LINES = (1 << IDX_W) * WAYS;

    logic [LINE_W-1:0] lines [LINES];
    logic [LINE_W-1:0] rd_line;

    // Fill a whole line, or merge one written word at the read location.
    always_ff @(posedge clk) begin
        if (fill_en)
            lines[{fill_idx, fill_way}] <= fill_line;
        else if (wr_en)
            lines[{rd_idx, rd_way}][rd_wsel*WORD_W +: WORD_W] <= wr_word;
    end

    assign rd_line = lines[{rd_idx, rd_way}];
    assign rd_word = rd_line[rd_wsel*WORD_W +: WORD_W];
endmodule

// File: rtl/vipt_cache.sv
// VIPT set-associative data cache. Stage 0 accepts a request and reads
// the set's tags using page-offset bits only. Stage 1 receives the
// physical page number, compares, answers, updates a word on a write
// hit, or starts a line fill on a read miss.
// Assumes: xlt_ppn/xlt_fault are valid in the cycle after acceptance;
// memory answers each line request with exactly one mem_rsp_valid pulse.
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int LINE_LOG  = 5,
    parameter int WAYS      = 4,
    parameter int PPN_W     = 20,
    parameter int WORD_W    = 32,
    localparam int IDX_W    = PAGE_BITS - LINE_LOG,
    localparam int WSEL_W   = LINE_LOG - $clog2(WORD_W / 8),
    localparam int OFF_W    = IDX_W + WSEL_W,
    localparam int LINE_W   = 8 << LINE_LOG,
    localparam int LADDR_W  = PPN_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [OFF_W-1:0]   req_woff,
    input  logic [WORD_W-1:0]  req_wdata,
    input  logic [PPN_W-1:0]   xlt_ppn,
    input  logic               xlt_fault,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [WORD_W-1:0]  rsp_rdata,
    output logic               mem_req_valid,
    output logic [LADDR_W-1:0] mem_req_line,
    input  logic               mem_rsp_valid,
    input  logic [LINE_W-1:0]  mem_rsp_line
);
    localparam int WAY_W = $clog2(WAYS);

    fill_state_e              state_q;
    logic                     s1_vld_q, s1_write_q;
    logic [IDX_W-1:0]         s1_idx_q;
    logic [WSEL_W-1:0]        s1_wsel_q;
    logic [WORD_W-1:0]        s1_wdata_q;
    logic [PPN_W-1:0]         fill_ppn_q;
    logic [IDX_W-1:0]         fill_idx_q;

    logic                     accept, s1_hit, s1_fill, fill_done, hit_any;
    logic [WAYS-1:0][PPN_W-1:0] set_tag;
    logic [WAYS-1:0]          set_vld, fill_sel;
    logic [WAY_W-1:0]         hit_way, vic_way;

    assign accept    = req_valid && req_ready;
    assign s1_hit    = s1_vld_q && !xlt_fault && hit_any;
    assign s1_fill   = s1_vld_q && !xlt_fault && !s1_write_q && !hit_any;
    assign req_ready = (state_q == ST_IDLE) && !s1_fill;
    assign fill_done = (state_q == ST_FILL) && mem_rsp_valid;
    assign fill_sel  = WAYS'(1) << vic_way;

    vipt_tag_store #(.IDX_W(IDX_W), .WAYS(WAYS), .TAG_W(PPN_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_en(accept), .rd_idx(req_woff[OFF_W-1:WSEL_W]),
        .fill_en(fill_done), .fill_idx(fill_idx_q), .fill_sel(fill_sel),
        .fill_tag(fill_ppn_q),
        .rd_tag(set_tag), .rd_vld(set_vld)
    );

    vipt_way_match #(.WAYS(WAYS), .TAG_W(PPN_W)) u_match (
        .clk(clk), .rst_n(rst_n),
        .tags(set_tag), .vld(set_vld), .ppn(xlt_ppn),
        .hit(hit_any), .hit_way(hit_way)
    );

    vipt_rr_victim #(.IDX_W(IDX_W), .WAYS(WAYS)) u_victim (
        .clk(clk), .rst_n(rst_n),
        .idx(fill_idx_q), .advance(fill_done), .way(vic_way)
    );

    vipt_data_store #(.IDX_W(IDX_W), .WAYS(WAYS), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_data (
        .clk(clk),
        .rd_idx(s1_idx_q), .rd_way(hit_way), .rd_wsel(s1_wsel_q), .rd_word(rsp_rdata),
        .wr_en(s1_hit && s1_write_q), .wr_word(s1_wdata_q),
        .fill_en(fill_done), .fill_idx(fill_idx_q), .fill_way(vic_way),
        .fill_line(mem_rsp_line)
    );

    // Stage-1 register: carries the accepted request to the compare cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld_q   <= 1'b0;
            s1_write_q <= 1'b0;
            s1_idx_q   <= '0;
            s1_wsel_q  <= '0;
            s1_wdata_q <= '0;
        end else begin
            s1_vld_q <= accept;
            if (accept) begin
                s1_write_q <= req_write;
                s1_idx_q   <= req_woff[OFF_W-1:WSEL_W];
                s1_wsel_q  <= req_woff[WSEL_W-1:0];
                s1_wdata_q <= req_wdata;
            end
        end
    end

    // Fill control: enter on a clean read miss, leave when the line arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            fill_ppn_q <= '0;
            fill_idx_q <= '0;
        end else if (state_q == ST_IDLE) begin
            if (s1_fill) begin
                state_q    <= ST_FILL;
                fill_ppn_q <= xlt_ppn;
                fill_idx_q <= s1_idx_q;
            end
        end else if (mem_rsp_valid) begin
            state_q <= ST_IDLE;
        end
    end

    assign rsp_valid     = s1_vld_q;
    assign rsp_hit       = s1_hit;
    assign mem_req_valid = (state_q == ST_FILL);
    assign mem_req_line  = {fill_ppn_q, fill_idx_q};

    assert_answer_next_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_no_accept_in_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    assert_fetch_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_line)));

    assert_miss_fetches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && !xlt_fault && !s1_write_q) |=> mem_req_valid);

    assert_fault_no_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && xlt_fault && !mem_req_valid) |=> !mem_req_valid);

    assert_write_no_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && s1_write_q && !mem_req_valid) |=> !mem_req_valid);
endmodule

// File: tb/vipt_cache_bench.sv
module vipt_cache_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_write, xlt_fault, mem_rsp_valid;
    logic         req_ready, rsp_valid, rsp_hit, mem_req_valid;
    logic [9:0]   req_woff;
    logic [31:0]  req_wdata, rsp_rdata;
    logic [19:0]  xlt_ppn;
    logic [26:0]  mem_req_line;
    logic [255:0] mem_rsp_line;

    always #4 clk = ~clk;

    vipt_cache u_vipt_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_woff(req_woff), .req_wdata(req_wdata),
        .xlt_ppn(xlt_ppn), .xlt_fault(xlt_fault),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line)
    );

    typedef struct {
        logic        hit;
        logic        chk_data;
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          total = 0, bad = 0, cyc = 0, n_fetch = 0, wait_cnt = 0;
    logic [26:0] last_line = '0;
    logic [19:0] pend_ppn = '0;
    logic        pend_fault = 1'b0;
    bit          done = 1'b0;

    function automatic logic [31:0] mem_word(input logic [26:0] la, input int w);
        return {5'b10110, la} + 32'(w);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model: answers each line fetch three cycles after seeing it.
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_line  = '0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) begin
                mem_rsp_valid = 1'b0;
            end else if (mem_req_valid) begin
                if (wait_cnt == 0) begin
                    n_fetch++;
                    last_line = mem_req_line;
                    wait_cnt  = 1;
                end else if (wait_cnt == 3) begin
                    for (int w = 0; w < 8; w++)
                        mem_rsp_line[w*32 +: 32] = mem_word(mem_req_line, w);
                    mem_rsp_valid = 1'b1;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // Monitor: pops one expected item per response and compares.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected response", {31'b0, rsp_hit}, 32'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(rsp_hit === e.hit, e.req, "hit", {31'b0, rsp_hit}, {31'b0, e.hit});
                    if (e.chk_data)
                        check(rsp_rdata === e.data, e.req, "rdata", rsp_rdata, e.data);
                end
            end
        end
    end

    // Driver: present a request, drive the previous one's translation.
    task automatic send(input logic wr, input logic [6:0] idx, input logic [2:0] w,
                        input logic [31:0] wd, input logic [19:0] ppn, input logic flt,
                        input logic exp_hit, input logic chk, input logic [31:0] exp_d,
                        input string req);
        exp_t e;
        e.hit = exp_hit; e.chk_data = chk; e.data = exp_d; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_woff = {idx, w}; req_wdata = wd;
        xlt_ppn = pend_ppn; xlt_fault = pend_fault;
        #1;
        while (req_ready !== 1'b1) begin
            @(negedge clk);
            #1;
        end
        pend_ppn = ppn; pend_fault = flt;
    endtask

    task automatic rd(input logic [6:0] idx, input logic [2:0] w, input logic [19:0] ppn,
                      input logic exp_hit, input string req);
        send(1'b0, idx, w, 32'h0, ppn, 1'b0, exp_hit, exp_hit,
             mem_word({ppn, idx}, int'(w)), req);
    endtask

    task automatic flush();
        @(negedge clk);
        req_valid = 1'b0;
        xlt_ppn = pend_ppn; xlt_fault = pend_fault;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        int c0, c1, f0;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_woff = '0;
        req_wdata = '0; xlt_ppn = '0; xlt_fault = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check(req_ready === 1'b1, "R1", "ready after reset", {31'b0, req_ready}, 32'h1);
        check(rsp_valid === 1'b0, "R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        check(mem_req_valid === 1'b0, "R1", "mem_req after reset", {31'b0, mem_req_valid}, 32'h0);

        // R1/R4: first read misses and fetches {ppn,set}
        rd(7'd3, 3'd2, 20'h00111, 1'b0, "R1");
        flush();
        check(n_fetch == 1, "R4", "fetch count", 32'(n_fetch), 32'd1);
        check(last_line == {20'h00111, 7'd3}, "R4", "fetch line", 32'(last_line),
              32'({20'h00111, 7'd3}));
        // R5: refetched data hits; R2: same page, other set is a separate line
        rd(7'd3, 3'd2, 20'h00111, 1'b1, "R5");
        rd(7'd3, 3'd7, 20'h00111, 1'b1, "R2");
        rd(7'd4, 3'd2, 20'h00111, 1'b0, "R2");
        rd(7'd4, 3'd0, 20'h00111, 1'b1, "R2");
        // R6: four pages share set 3, fifth evicts the first
        rd(7'd3, 3'd1, 20'h00222, 1'b0, "R6");
        rd(7'd3, 3'd1, 20'h00333, 1'b0, "R6");
        rd(7'd3, 3'd1, 20'h00444, 1'b0, "R6");
        rd(7'd3, 3'd6, 20'h00111, 1'b1, "R6");
        rd(7'd3, 3'd1, 20'h00555, 1'b0, "R6");
        rd(7'd3, 3'd0, 20'h00222, 1'b1, "R6");
        rd(7'd3, 3'd3, 20'h00333, 1'b1, "R6");
        rd(7'd3, 3'd4, 20'h00444, 1'b1, "R6");
        rd(7'd3, 3'd5, 20'h00555, 1'b1, "R6");
        rd(7'd3, 3'd0, 20'h00111, 1'b0, "R6");
        flush();
        // now set 3 holds 111,555,333,444 (222 evicted)
        rd(7'd3, 3'd0, 20'h00111, 1'b1, "R6");
        flush();
        f0 = n_fetch;
        // R7: faults never hit, never fetch
        send(1'b0, 7'd3, 3'd4, 32'h0, 20'h00444, 1'b1, 1'b0, 1'b0, 32'h0, "R7");
        send(1'b0, 7'd9, 3'd0, 32'h0, 20'h00777, 1'b1, 1'b0, 1'b0, 32'h0, "R7");
        flush();
        check(n_fetch == f0, "R7", "no fetch on fault", 32'(n_fetch), 32'(f0));
        // R8: write hit then immediate read-back; R7: faulted write stores nothing
        send(1'b1, 7'd3, 3'd5, 32'hDEADBEEF, 20'h00333, 1'b0, 1'b1, 1'b0, 32'h0, "R8");
        send(1'b0, 7'd3, 3'd5, 32'h0, 20'h00333, 1'b0, 1'b1, 1'b1, 32'hDEADBEEF, "R8");
        send(1'b1, 7'd3, 3'd5, 32'h12345678, 20'h00333, 1'b1, 1'b0, 1'b0, 32'h0, "R7");
        send(1'b0, 7'd3, 3'd5, 32'h0, 20'h00333, 1'b0, 1'b1, 1'b1, 32'hDEADBEEF, "R7");
        // R8: write miss neither fills nor changes resident lines
        send(1'b1, 7'd3, 3'd5, 32'hCAFEF00D, 20'h00999, 1'b0, 1'b0, 1'b0, 32'h0, "R8");
        send(1'b0, 7'd3, 3'd5, 32'h0, 20'h00333, 1'b0, 1'b1, 1'b1, 32'hDEADBEEF, "R8");
        flush();
        check(n_fetch == f0, "R8", "no fetch on write miss", 32'(n_fetch), 32'(f0));
        // R9: back-to-back hits accepted every cycle
        rd(7'd3, 3'd1, 20'h00444, 1'b1, "R9");
        c0 = cyc;
        rd(7'd3, 3'd2, 20'h00555, 1'b1, "R9");
        rd(7'd4, 3'd3, 20'h00111, 1'b1, "R9");
        c1 = cyc;
        check(c1 - c0 == 2, "R9", "cycles for 3 hits", 32'(c1 - c0), 32'd2);
        flush();
        // R4: a miss followed at once by a hit; the hit waits for the fill
        rd(7'd20, 3'd1, 20'h00ABC, 1'b0, "R4");
        send(1'b0, 7'd3, 3'd5, 32'h0, 20'h00333, 1'b0, 1'b1, 1'b1, 32'hDEADBEEF, "R4");
        flush();
        check(n_fetch == f0 + 1, "R4", "single fetch", 32'(n_fetch), 32'(f0 + 1));
        check(last_line == {20'h00ABC, 7'd20}, "R4", "fetch line", 32'(last_line),
              32'({20'h00ABC, 7'd20}));
        rd(7'd20, 3'd7, 20'h00ABC, 1'b1, "R5");
        flush();
        check(sb_q.size() == 0, "R3", "responses outstanding", 32'(sb_q.size()), 32'd0);
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule